// File: doc/BRIEF.md
# Keyed System Control Register File

This block is a bank of 32-bit configuration and fault-status registers that a processor subsystem reaches through a small word-addressed read/write port. It holds a vector table base, a key-protected application control word with a priority grouping field and two reset-request bits, a sleep control word, a pend control word for a timer and a service request, three handler priority words, a handler enable/pending/active word, four fault status words and two fault address words. Arbitration of exceptions happens elsewhere. This block only stores state and exports the grouping field, the handler bits, the two pend flags and a one-cycle reset request pulse.

The command side is a valid/ready pair. `cmd_ready` is held high, so a command is accepted in every cycle where `cmd_valid` is high. A read returns its data on `rsp_data` with `rsp_valid` high exactly one cycle after acceptance. The response side has no ready input, so the consumer must take the response in that cycle. Fault logic sets status bits through four set vectors. Software clears those bits by writing ones.

Word offsets (`cmd_addr`): 0 vector base, 1 application control, 2 sleep control, 3 pend control, 4/5/6 handler priority words A/B/C, 7 handler control, 8/9/10/11 fault status words F0..F3, 12/13 fault address words, 14..15 unmapped.

Top module: `sysctl_keyed_regs`

## Requirements
- R1: The vector base register keeps only the bits of written data in mask 0x3FFFFF80. Its reset value is 0.
- R2: A write to the application control word has effect only when data bits 31:16 equal 0x05FA. A keyed write loads the grouping field from bits 10:8, and that field drives `prigroup`. A read returns 0xFA05 in bits 31:16, the grouping field in bits 10:8, and zeros elsewhere.
- R3: A keyed write with bit 2 (system reset) or bit 0 (vector reset) set raises `reset_req` for exactly one cycle, in the cycle after the write. Neither bit is retained, so both read back as 0. An unkeyed write never raises `reset_req`.
- R4: A read of the sleep control word returns the last written value masked with 0x16.
- R5: Each fault status word F0..F3 sets a bit in the cycle after the matching `fltN_set` bit is high. A write clears each bit written as 1 and leaves bits written as 0 unchanged. When a set and a clear hit the same bit in the same cycle, the set wins.
- R6: In the pend control word, bit 26 sets the timer pend and bit 25 clears it, and set takes precedence over clear. Bit 28 sets the service pend and bit 27 clears it. Both are applied in that order, so clear wins. A read returns the service pend in bit 28 and the timer pend in bit 26. The two flags drive `svc_pend` and `tmr_pend`.
- R7: Handler priority word A holds bytes at bits 7:0, 15:8 and 23:16. Word B holds one byte at bits 31:24. Word C holds bytes at bits 7:0, 23:16 and 31:24. All other bytes read as 0 and ignore writes.
- R8: A write to the handler control word loads the enables from bits 2:0, the pending bits from bits 7:4 and the active bits from bits 14:8. These fields drive `hnd_enable`, `hnd_pending` and `hnd_active`. A read returns them in the same positions, with all other bits 0.
- R9: A write to an unmapped offset changes no register, and a read of an unmapped offset returns 0.
- R10: `cmd_ready` is always 1. A read accepted at one clock edge gives `rsp_valid` = 1 with its data after that edge, and `rsp_valid` is 0 in cycles that follow no read.
- R11: The two fault address words store and return all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1) |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 4 | Word offset |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Read data |
| flt0_set | input | 32 | Set mask for fault status F0 |
| flt1_set | input | 32 | Set mask for fault status F1 |
| flt2_set | input | 32 | Set mask for fault status F2 |
| flt3_set | input | 32 | Set mask for fault status F3 |
| reset_req | output | 1 | One-cycle reset request pulse |
| prigroup | output | 3 | Priority grouping field |
| hnd_enable | output | 3 | Handler fault enables |
| hnd_pending | output | 4 | Handler pending bits |
| hnd_active | output | 7 | Handler active bits |
| tmr_pend | output | 1 | Timer pend flag |
| svc_pend | output | 1 | Service pend flag |

## Verification
The hardest case to reach is a hardware set and a software clear that hit the same fault status bit in the same cycle. The set vectors and the bus write are independent inputs, so a directed task drives `flt2_set` and the clearing write on the same falling edge. It then reads the word back to confirm that the bit survived. The single-cycle `reset_req` pulse is checked the same way: the pulse is sampled on the edge after the keyed write and again one cycle later.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW = 32;
  localparam int OFS_VEC   = 0;
  localparam int OFS_APP   = 1;
  localparam int OFS_SLEEP = 2;
  localparam int OFS_PEND  = 3;
  localparam int OFS_PRIO  = 4;
  localparam int NUM_PRIO  = 3;
  localparam int OFS_HCTL  = 7;
  localparam int OFS_FLT   = 8;
  localparam int NUM_FLT   = 4;
  localparam int OFS_FADR  = 12;
  localparam int NUM_FADR  = 2;
  localparam logic [15:0] WR_KEY = 16'h05FA;
  localparam logic [15:0] RD_KEY = 16'hFA05;
  localparam logic [DW-1:0] VEC_MASK   = 32'h3FFF_FF80;
  localparam logic [DW-1:0] SLEEP_MASK = 32'h0000_0016;
  localparam logic [DW-1:0] HCTL_MASK  = 32'h0000_7FF7;

  function automatic logic [DW-1:0] prio_lanes(int idx);
    case (idx)
      0:       return 32'h00FF_FFFF;
      1:       return 32'hFF00_0000;
      default: return 32'hFFFF_00FF;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_keyed_ctl.sv
module sysctl_keyed_ctl
  import sysctl_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] key,
  input  logic [2:0]  grp_in,
  input  logic        sys_rq,
  input  logic        vec_rq,
  output logic [2:0]  group_o,
  output logic        rst_req_o
);
  logic key_ok;
  assign key_ok = wr_en && (key == WR_KEY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      group_o   <= '0;
      rst_req_o <= 1'b0;
    end else begin
      if (key_ok) group_o <= grp_in;
      rst_req_o <= key_ok && (sys_rq || vec_rq) && !rst_req_o;
    end
  end

  // R2
  unkeyed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && key != WR_KEY) |=> $stable(group_o));
  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);
endmodule

// File: rtl/sysctl_w1c_reg.sv
module sysctl_w1c_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] set_mask,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (q & ~(clr_en ? clr_mask : '0)) | set_mask;
  end

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && set_mask == '0) |=> $stable(q));
  // R5
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_mask != '0) |=> ((q & $past(set_mask)) == $past(set_mask)));
endmodule

// File: rtl/sysctl_prio_bank.sv
module sysctl_prio_bank
  import sysctl_pkg::*;
#(
  parameter int NW = NUM_PRIO
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NW-1:0]         wr_sel,
  input  logic [DW-1:0]         wdata,
  output logic [NW-1:0][DW-1:0] words
);
  for (genvar i = 0; i < NW; i++) begin : g_word
    localparam logic [DW-1:0] LANES = prio_lanes(i);
    always_ff @(posedge clk) begin
      if (!rst_n)         words[i] <= '0;
      else if (wr_sel[i]) words[i] <= wdata & LANES;
    end
    // R7
    unused_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (words[i] & ~LANES) == '0);
  end
endmodule

// File: rtl/sysctl_keyed_regs.sv
module sysctl_keyed_regs
  import sysctl_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_write,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] cmd_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  input  logic [DW-1:0] flt0_set,
  input  logic [DW-1:0] flt1_set,
  input  logic [DW-1:0] flt2_set,
  input  logic [DW-1:0] flt3_set,
  output logic          reset_req,
  output logic [2:0]    prigroup,
  output logic [2:0]    hnd_enable,
  output logic [3:0]    hnd_pending,
  output logic [6:0]    hnd_active,
  output logic          tmr_pend,
  output logic          svc_pend
);
  logic wr, rd;
  assign cmd_ready = 1'b1;
  assign wr = cmd_valid && cmd_write;
  assign rd = cmd_valid && !cmd_write;

  function automatic logic hit(logic [AW-1:0] a, int ofs);
    return a == AW'(ofs);
  endfunction

  // plain storage
  logic [DW-1:0] vec_q;
  logic [4:0]    sleep_q;
  logic [DW-1:0] fadr_q [NUM_FADR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_q       <= '0;
      sleep_q     <= '0;
      tmr_pend    <= 1'b0;
      svc_pend    <= 1'b0;
      hnd_enable  <= '0;
      hnd_pending <= '0;
      hnd_active  <= '0;
    end else if (wr) begin
      if (hit(cmd_addr, OFS_VEC))   vec_q   <= cmd_wdata & VEC_MASK;
      if (hit(cmd_addr, OFS_SLEEP)) sleep_q <= cmd_wdata[4:0];
      if (hit(cmd_addr, OFS_PEND)) begin
        if (cmd_wdata[28]) svc_pend <= 1'b1;
        if (cmd_wdata[27]) svc_pend <= 1'b0;
        if (cmd_wdata[26])      tmr_pend <= 1'b1;
        else if (cmd_wdata[25]) tmr_pend <= 1'b0;
      end
      if (hit(cmd_addr, OFS_HCTL)) begin
        hnd_enable  <= cmd_wdata[2:0];
        hnd_pending <= cmd_wdata[7:4];
        hnd_active  <= cmd_wdata[14:8];
      end
    end
  end

  for (genvar i = 0; i < NUM_FADR; i++) begin : g_fadr
    always_ff @(posedge clk) begin
      if (!rst_n)                                fadr_q[i] <= '0;
      else if (wr && hit(cmd_addr, OFS_FADR + i)) fadr_q[i] <= cmd_wdata;
    end
  end

  // keyed application control
  sysctl_keyed_ctl u_app (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr && hit(cmd_addr, OFS_APP)),
    .key      (cmd_wdata[31:16]),
    .grp_in   (cmd_wdata[10:8]),
    .sys_rq   (cmd_wdata[2]),
    .vec_rq   (cmd_wdata[0]),
    .group_o  (prigroup),
    .rst_req_o(reset_req)
  );

  // handler priority words
  logic [NUM_PRIO-1:0]         prio_sel;
  logic [NUM_PRIO-1:0][DW-1:0] prio_q;
  for (genvar i = 0; i < NUM_PRIO; i++) begin : g_psel
    assign prio_sel[i] = wr && hit(cmd_addr, OFS_PRIO + i);
  end
  sysctl_prio_bank #(.NW(NUM_PRIO)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_sel(prio_sel),
    .wdata (cmd_wdata),
    .words (prio_q)
  );

  // fault status words, write-one-to-clear
  logic [DW-1:0] flt_set [NUM_FLT];
  logic [DW-1:0] flt_q   [NUM_FLT];
  assign flt_set[0] = flt0_set;
  assign flt_set[1] = flt1_set;
  assign flt_set[2] = flt2_set;
  assign flt_set[3] = flt3_set;
  for (genvar i = 0; i < NUM_FLT; i++) begin : g_flt
    sysctl_w1c_reg #(.W(DW)) u_flt (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_en  (wr && hit(cmd_addr, OFS_FLT + i)),
      .clr_mask(cmd_wdata),
      .set_mask(flt_set[i]),
      .q       (flt_q[i])
    );
  end

  // read path
  logic [DW-1:0] rmux;
  always_comb begin
    rmux = '0;
    case (int'(cmd_addr))
      OFS_VEC:       rmux = vec_q;
      OFS_APP:       rmux = {RD_KEY, 5'b0, prigroup, 8'b0};
      OFS_SLEEP:     rmux = {27'b0, sleep_q} & SLEEP_MASK;
      OFS_PEND:      rmux = {3'b0, svc_pend, 1'b0, tmr_pend, 26'b0};
      OFS_PRIO:      rmux = prio_q[0];
      OFS_PRIO + 1:  rmux = prio_q[1];
      OFS_PRIO + 2:  rmux = prio_q[2];
      OFS_HCTL:      rmux = {17'b0, hnd_active, hnd_pending, 1'b0, hnd_enable};
      OFS_FLT:       rmux = flt_q[0];
      OFS_FLT + 1:   rmux = flt_q[1];
      OFS_FLT + 2:   rmux = flt_q[2];
      OFS_FLT + 3:   rmux = flt_q[3];
      OFS_FADR:      rmux = fadr_q[0];
      OFS_FADR + 1:  rmux = fadr_q[1];
      default:       rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd;
      rsp_data  <= rd ? rmux : '0;
    end
  end

  // R6
  tmr_set_prec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit(cmd_addr, OFS_PEND) && cmd_wdata[26]) |=> tmr_pend);
  // R6
  svc_clr_prec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit(cmd_addr, OFS_PEND) && cmd_wdata[27]) |=> !svc_pend);
  // R9
  unmapped_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && cmd_addr > AW'(OFS_FADR + NUM_FADR - 1)) |=> $stable(vec_q));
  // R10
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> !rsp_valid);
endmodule

// File: tb/sysctl_keyed_regs_test.sv
module sysctl_keyed_regs_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0, cmd_write = 0;
  logic        cmd_ready;
  logic [3:0]  cmd_addr = 0;
  logic [31:0] cmd_wdata = 0;
  logic        rsp_valid;
  logic [31:0] rsp_data;
  logic [31:0] f0 = 0, f1 = 0, f2 = 0, f3 = 0;
  logic        reset_req, tmr_pend, svc_pend;
  logic [2:0]  prigroup, hnd_enable;
  logic [3:0]  hnd_pending;
  logic [6:0]  hnd_active;

  int checks = 0, failures = 0;
  bit done = 0;
  logic pulse_seen;

  always #4 clk = ~clk;

  sysctl_keyed_regs uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .flt0_set(f0), .flt1_set(f1), .flt2_set(f2), .flt3_set(f3),
    .reset_req(reset_req), .prigroup(prigroup), .hnd_enable(hnd_enable),
    .hnd_pending(hnd_pending), .hnd_active(hnd_active),
    .tmr_pend(tmr_pend), .svc_pend(svc_pend));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 1; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    pulse_seen = reset_req;
    cmd_valid = 0; cmd_write = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    cmd_valid = 1; cmd_write = 0; cmd_addr = a;
    @(negedge clk);
    cmd_valid = 0;
    check("R10 rsp_valid", 32'(rsp_valid), 32'd1);
    d = rsp_data;
  endtask

  task automatic rd_chk(string req, logic [3:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic t_reset;
    check("R2 prigroup reset", 32'(prigroup), 0);
    check("R10 ready", 32'(cmd_ready), 1);
    check("R10 no rsp idle", 32'(rsp_valid), 0);
    rd_chk("R1 vec reset", 4'd0, 0);
    rd_chk("R2 app reset read", 4'd1, 32'hFA05_0000);
    @(negedge clk);
    check("R10 rsp drops", 32'(rsp_valid), 0);
  endtask

  task automatic t_vec;
    wr(4'd0, 32'hFFFF_FFFF);
    rd_chk("R1 vec mask", 4'd0, 32'h3FFF_FF80);
    wr(4'd0, 32'h1234_5678);
    rd_chk("R1 vec pattern", 4'd0, 32'h1234_5600);
  endtask

  task automatic t_key;
    wr(4'd1, 32'h1234_0500);
    check("R2 bad key group", 32'(prigroup), 0);
    rd_chk("R2 bad key read", 4'd1, 32'hFA05_0000);
    wr(4'd1, 32'h05FA_0300);
    check("R2 keyed group", 32'(prigroup), 3);
    check("R3 no pulse", 32'(pulse_seen), 0);
    rd_chk("R2 keyed read", 4'd1, 32'hFA05_0300);
  endtask

  task automatic t_rst;
    wr(4'd1, 32'h05FA_0304);
    check("R3 sys pulse", 32'(pulse_seen), 1);
    @(negedge clk);
    check("R3 pulse ends", 32'(reset_req), 0);
    rd_chk("R3 not retained", 4'd1, 32'hFA05_0300);
    wr(4'd1, 32'h05FA_0301);
    check("R3 vec pulse", 32'(pulse_seen), 1);
    wr(4'd1, 32'hAAAA_0705);
    check("R3 unkeyed no pulse", 32'(pulse_seen), 0);
    check("R2 unkeyed group", 32'(prigroup), 3);
  endtask

  task automatic t_sleep;
    wr(4'd2, 32'hFFFF_FFFF);
    rd_chk("R4 sleep mask", 4'd2, 32'h0000_0016);
    wr(4'd2, 32'h0000_0004);
    rd_chk("R4 sleep pattern", 4'd2, 32'h0000_0004);
  endtask

  task automatic t_fault;
    @(negedge clk); f0 = 32'h0000_00F0;
    @(negedge clk); f0 = 0;
    rd_chk("R5 set", 4'd8, 32'h0000_00F0);
    wr(4'd8, 32'h0000_0030);
    rd_chk("R5 clear ones", 4'd8, 32'h0000_00C0);
    wr(4'd8, 32'h0000_0000);
    rd_chk("R5 zeros ignored", 4'd8, 32'h0000_00C0);
    @(negedge clk); f1 = 32'h4000_0002;
    @(negedge clk); f1 = 0;
    wr(4'd9, 32'hFFFF_FFFF);
    rd_chk("R5 full clear", 4'd9, 0);
    @(negedge clk); f2 = 32'h0000_0001;
    cmd_valid = 1; cmd_write = 1; cmd_addr = 4'd10; cmd_wdata = 32'h0000_0001;
    @(negedge clk); f2 = 0; cmd_valid = 0; cmd_write = 0;
    rd_chk("R5 set beats clear", 4'd10, 32'h0000_0001);
    @(negedge clk); f3 = 32'h8000_0000;
    @(negedge clk); f3 = 0;
    rd_chk("R5 fault3 set", 4'd11, 32'h8000_0000);
  endtask

  task automatic t_pend;
    wr(4'd3, 32'h0600_0000);
    check("R6 tmr set wins", 32'(tmr_pend), 1);
    wr(4'd3, 32'h0200_0000);
    check("R6 tmr clear", 32'(tmr_pend), 0);
    wr(4'd3, 32'h1000_0000);
    check("R6 svc set", 32'(svc_pend), 1);
    rd_chk("R6 pend read", 4'd3, 32'h1000_0000);
    wr(4'd3, 32'h1800_0000);
    check("R6 svc clear wins", 32'(svc_pend), 0);
  endtask

  task automatic t_prio;
    wr(4'd4, 32'hFFFF_FFFF);
    rd_chk("R7 word A", 4'd4, 32'h00FF_FFFF);
    wr(4'd5, 32'hFFFF_FFFF);
    rd_chk("R7 word B", 4'd5, 32'hFF00_0000);
    wr(4'd6, 32'hFFFF_FFFF);
    rd_chk("R7 word C", 4'd6, 32'hFFFF_00FF);
    wr(4'd4, 32'h1122_3344);
    rd_chk("R7 word A pattern", 4'd4, 32'h0022_3344);
    wr(4'd6, 32'h1122_3344);
    rd_chk("R7 word C pattern", 4'd6, 32'h1122_0044);
  endtask

  task automatic t_hctl;
    wr(4'd7, 32'hFFFF_FFFF);
    check("R8 enable", 32'(hnd_enable), 32'h7);
    check("R8 pending", 32'(hnd_pending), 32'hF);
    check("R8 active", 32'(hnd_active), 32'h7F);
    rd_chk("R8 read all", 4'd7, 32'h0000_7FF7);
    wr(4'd7, 32'h0000_0125);
    check("R8 enable pat", 32'(hnd_enable), 32'h5);
    check("R8 pending pat", 32'(hnd_pending), 32'h2);
    check("R8 active pat", 32'(hnd_active), 32'h1);
  endtask

  task automatic t_unmapped;
    wr(4'd14, 32'hFFFF_FFFF);
    wr(4'd15, 32'hFFFF_FFFF);
    rd_chk("R9 unmapped read", 4'd15, 0);
    rd_chk("R9 vec untouched", 4'd0, 32'h1234_5600);
    rd_chk("R9 fault0 untouched", 4'd8, 32'h0000_00C0);
  endtask

  task automatic t_fadr;
    wr(4'd12, 32'hDEAD_BEEF);
    wr(4'd13, 32'h0BAD_F00D);
    rd_chk("R11 fadr0", 4'd12, 32'hDEAD_BEEF);
    rd_chk("R11 fadr1", 4'd13, 32'h0BAD_F00D);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_vec();
    t_key();
    t_rst();
    t_sleep();
    t_fault();
    t_pend();
    t_prio();
    t_hctl();
    t_unmapped();
    t_fadr();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule